// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This block paces the retries of one hardware thread that competes for a contended compare-and-swap. Each time the requester's attempt fails it pulses `fail_pulse`. The controller raises `busy` for a wait period and drops it when the wait has run out, after which the requester may try again. The wait grows exponentially with consecutive failures. A held backoff count starts at 1 and doubles after every accepted failure until it has gone past a ceiling of 4096. Once it is past the ceiling it stays where it is. A `success_pulse` returns the count to 1.

Two wait styles exist, and the static input `mode_pause` chooses between them. In loop mode the controller times the wait itself. It runs one more iteration than the backoff count, and each iteration is three fixed delay slots of 43 cycles. In pause mode the controller issues a single write to an external pause counter. The written value is the backoff count scaled up by 2^7. The controller then waits until that unit reports completion on `pause_done`.

The pause write is a one-cycle command with no back-pressure. `pause_wr` is high for exactly one cycle, and `pause_val` is valid in that cycle. The pause unit must accept the write in that cycle. It answers later with a single-cycle `pause_done`. All other pins are plain level or pulse controls.

Top module: `bo_retry_ctrl`

## Requirements
- R1: After reset `busy` and `pause_wr` are low, and the backoff count is 1, so the first accepted failure waits with count 1.
- R2: Every accepted failure uses the current backoff count for its wait and then doubles the count for the next failure, giving 1, 2, 4, 8, ...
- R3: A count already greater than 4096 is not doubled again, so the sequence ends 2048, 4096, 8192, 8192, 8192, ...
- R4: In loop mode (`mode_pause`=0) `busy` stays high for exactly (count+1)*3*43 cycles per accepted failure.
- R5: In pause mode (`mode_pause`=1) `pause_wr` is high for exactly one cycle, the cycle after the accepted failure, with `pause_val` = count << 7.
- R6: In pause mode `busy` stays high until `pause_done` is sampled after the write cycle and falls in the next cycle. A `pause_done` in the write cycle itself is ignored.
- R7: `busy` rises in the cycle after an accepted `fail_pulse`.
- R8: A `fail_pulse` while `busy` is high is ignored. It neither lengthens the current wait nor doubles the count.
- R9: `success_pulse` sets the backoff count to 1. If it arrives in the same cycle as an accepted failure, the wait uses the old count and the count after it is 1.
- R10: `mode_pause` is sampled when a failure is accepted. A loop-mode wait never raises `pause_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_pulse | input | 1 | Requester reports a failed attempt |
| success_pulse | input | 1 | Requester reports a successful attempt |
| mode_pause | input | 1 | 1: pause-counter wait, 0: loop-timed wait |
| pause_done | input | 1 | Pause unit reports that the requested delay has elapsed |
| busy | output | 1 | Requester must hold off while high |
| pause_wr | output | 1 | One-cycle write command to the pause unit |
| pause_val | output | 32 | Scaled delay value, valid while `pause_wr` is high |

## Verification
In loop mode the bench measures how long `busy` stays high over a run of consecutive failures. This distinguishes a correct doubling from an off-by-one iteration count and from a wrong slot length. One of these waits is hit with an extra failure pulse partway through, which shows whether ignored failures leak into the wait or into the count. In pause mode a long run of failures walks the written value up through the ceiling, which separates a cap at "greater than" from one at "greater or equal". Completion pulses are placed both in the write cycle and later, and a success is applied between runs to show the return to 1.

// File: rtl/bo_pkg.sv
package bo_pkg;
  typedef enum logic [1:0] {
    PP_IDLE = 2'd0,
    PP_REQ  = 2'd1,
    PP_WAIT = 2'd2
  } pp_state_t;
endpackage

// File: rtl/bo_backoff_reg.sv
module bo_backoff_reg #(
  parameter int CAP  = 4096,
  parameter int BO_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            clear,
  output logic [BO_W-1:0] bo
);
  localparam logic [BO_W-1:0] CAP_V = BO_W'(CAP);
  localparam logic [BO_W-1:0] ONE_V = BO_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                       bo <= ONE_V;
    else if (clear)                   bo <= ONE_V;
    else if (advance && bo <= CAP_V)  bo <= bo << 1;
  end

  AST_BO_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bo) == 1); // R2
  AST_BO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    bo <= (CAP_V << 1)); // R3
  AST_BO_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && bo <= CAP_V) |=> bo == ($past(bo) << 1)); // R2
  AST_BO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && bo > CAP_V) |=> $stable(bo)); // R3
  AST_BO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> bo == ONE_V); // R9
endmodule

// File: rtl/bo_spin_timer.sv
module bo_spin_timer #(
  parameter int BO_W  = 14,
  parameter int OPS   = 3,
  parameter int SLOT  = 43
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BO_W-1:0] count,
  output logic            busy
);
  localparam int OP_W = $clog2(OPS + 1);
  localparam int SL_W = $clog2(SLOT + 1);
  localparam logic [OP_W-1:0] OP_RLD = OP_W'(OPS - 1);
  localparam logic [SL_W-1:0] SL_RLD = SL_W'(SLOT - 1);

  logic [BO_W-1:0] iter_q;
  logic [OP_W-1:0] op_q;
  logic [SL_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      iter_q <= '0;
      op_q   <= '0;
      slot_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      iter_q <= count;
      op_q   <= OP_RLD;
      slot_q <= SL_RLD;
    end else if (busy) begin
      if (slot_q != '0) begin
        slot_q <= slot_q - 1'b1;
      end else if (op_q != '0) begin
        op_q   <= op_q - 1'b1;
        slot_q <= SL_RLD;
      end else if (iter_q != '0) begin
        iter_q <= iter_q - 1'b1;
        op_q   <= OP_RLD;
        slot_q <= SL_RLD;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  AST_SPIN_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R7
  AST_SPIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && iter_q != '0) |=> busy); // R4
endmodule

// File: rtl/bo_pause_port.sv
module bo_pause_port
  import bo_pkg::*;
#(
  parameter int BO_W  = 14,
  parameter int SHIFT = 7,
  parameter int PV_W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BO_W-1:0] count,
  input  logic            done,
  output logic            wr,
  output logic [PV_W-1:0] val,
  output logic            busy
);
  pp_state_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= PP_IDLE;
      val  <= '0;
    end else begin
      unique case (st_q)
        PP_IDLE: if (start) begin
          st_q <= PP_REQ;
          val  <= PV_W'(count) << SHIFT;
        end
        PP_REQ:  st_q <= PP_WAIT;
        PP_WAIT: if (done) st_q <= PP_IDLE;
        default: st_q <= PP_IDLE;
      endcase
    end
  end

  assign wr   = (st_q == PP_REQ);
  assign busy = (st_q != PP_IDLE);

  AST_WR_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> wr); // R5
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !wr && busy); // R5
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr && done) |=> !busy); // R6
endmodule

// File: rtl/bo_retry_ctrl.sv
module bo_retry_ctrl #(
  parameter int CAP       = 4096,
  parameter int OPS       = 3,
  parameter int SLOT      = 43,
  parameter int SHIFT     = 7,
  parameter int PV_W      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fail_pulse,
  input  logic            success_pulse,
  input  logic            mode_pause,
  input  logic            pause_done,
  output logic            busy,
  output logic            pause_wr,
  output logic [PV_W-1:0] pause_val
);
  localparam int BO_W = $clog2(CAP) + 2;

  logic [BO_W-1:0] bo;
  logic accept, spin_busy, pause_busy;

  assign accept = fail_pulse && !busy;
  assign busy   = spin_busy || pause_busy;

  bo_backoff_reg #(.CAP(CAP), .BO_W(BO_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .advance(accept), .clear(success_pulse), .bo(bo)
  );

  bo_spin_timer #(.BO_W(BO_W), .OPS(OPS), .SLOT(SLOT)) u_spin (
    .clk(clk), .rst_n(rst_n), .start(accept && !mode_pause),
    .count(bo), .busy(spin_busy)
  );

  bo_pause_port #(.BO_W(BO_W), .SHIFT(SHIFT), .PV_W(PV_W)) u_pause (
    .clk(clk), .rst_n(rst_n), .start(accept && mode_pause), .count(bo),
    .done(pause_done), .wr(pause_wr), .val(pause_val), .busy(pause_busy)
  );

  AST_LOOP_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    spin_busy |-> !pause_wr); // R10
  AST_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(spin_busy && pause_busy)); // R8
  AST_BUSY_FAIL_IGN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fail_pulse && !success_pulse) |=> $stable(bo)); // R8
endmodule

// File: tb/sim_bo_retry_ctrl.sv
`timescale 1ns/1ps
module sim_bo_retry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fail_pulse = 1'b0, success_pulse = 1'b0, mode_pause = 1'b0, pause_done = 1'b0;
  logic busy, pause_wr;
  logic [31:0] pause_val;

  int nvec = 0, nfail = 0, cyc = 0;
  localparam int LOOP_UNIT = 3 * 43;

  always #10 clk = ~clk;

  bo_retry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fail_pulse(fail_pulse), .success_pulse(success_pulse),
    .mode_pause(mode_pause), .pause_done(pause_done), .busy(busy),
    .pause_wr(pause_wr), .pause_val(pause_val)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      finish_run();
    end
  end

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(pause_wr == 1'b0, "R1 pause_wr", pause_wr, 0);
  endtask

  // R4/R7/R8/R10: one loop-mode wait, optionally poked with an ignored fail
  task automatic t_loop_wait(input int bo_exp, input bit poke);
    int cnt = 0;
    bit saw_wr = 1'b0;
    fail_pulse = 1'b1;
    @(negedge clk);
    fail_pulse = 1'b0;
    chk(busy == 1'b1, "R7 busy rise", busy, 1);
    while (busy === 1'b1) begin
      cnt++;
      if (pause_wr) saw_wr = 1'b1;
      fail_pulse = (poke && cnt == 10);
      @(negedge clk);
    end
    fail_pulse = 1'b0;
    chk(cnt == (bo_exp + 1) * LOOP_UNIT, poke ? "R8/R4 loop wait" : "R4 loop wait",
        cnt, (bo_exp + 1) * LOOP_UNIT);
    chk(!saw_wr, "R10 no pause_wr in loop mode", saw_wr, 0);
  endtask

  // R5/R6: one pause-mode wait
  task automatic t_pause_wait(input longint bo_exp);
    fail_pulse = 1'b1;
    @(negedge clk);
    fail_pulse = 1'b0;
    chk(pause_wr == 1'b1, "R5 pause_wr", pause_wr, 1);
    chk(pause_val == 32'(bo_exp << 7), "R5/R2/R3 pause_val", pause_val, bo_exp << 7);
    pause_done = 1'b1;            // lands in write cycle: ignored
    @(negedge clk);
    pause_done = 1'b0;
    chk(pause_wr == 1'b0, "R5 single write", pause_wr, 0);
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R6 hold until done", busy, 1);
    pause_done = 1'b1;
    @(negedge clk);
    pause_done = 1'b0;
    chk(busy == 1'b0, "R6 release", busy, 0);
  endtask

  task automatic t_success();
    success_pulse = 1'b1;
    @(negedge clk);
    success_pulse = 1'b0;
    @(negedge clk);
  endtask

  // R2/R8: loop-mode doubling with an ignored mid-wait fail
  task automatic t_loop_series();
    mode_pause = 1'b0;
    t_loop_wait(1, 1'b0);
    t_loop_wait(2, 1'b1);
    t_loop_wait(4, 1'b0);   // R2, R8: only one doubling per accepted fail
  endtask

  // R9: success returns the count to 1
  task automatic t_success_reset();
    t_success();
    t_loop_wait(1, 1'b0);   // R9
  endtask

  // R2/R3: pause-mode walk through the ceiling
  task automatic t_pause_series();
    longint e = 2;          // count after the loop-mode wait above
    mode_pause = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      t_pause_wait(e);
      if (e <= 4096) e = e * 2;
    end
    chk(e == 8192, "R3 ceiling", e, 8192);
    t_success();
    t_pause_wait(1);        // R9 in pause mode
  endtask

  initial begin
    t_reset();
    t_loop_series();
    t_success_reset();
    t_pause_series();
    finish_run();
  end
endmodule